// File: doc/BRIEF.md
# Boundary-Scan Test Access Controller

This block is the serial test port of a chip. An external tester drives a test clock, a mode-select line and a serial data input, and can also pull an optional active-low reset. Under those pins the block walks a sixteen-state control machine. Through that machine the tester loads a two-bit instruction and then scans data through whichever register the instruction names. The result comes back on a serial data output.

The block holds the control machine, the instruction register with its decode, and a one-bit bypass register. The boundary register sits outside the block. For that register the block produces capture, shift and update enables and a mode flag that hands the pins to the register. It takes the register's serial output back in. The serial output is retimed to the falling test-clock edge. A separate enable flag marks the cycles in which the output carries valid data.

Top module: `tap_ctrl`

## Requirements
- R1: The control machine advances on the rising edge of `tck` as `tms` directs. Five consecutive rising edges with `tms` high reach the reset state from any of the sixteen states. In the reset state the active instruction becomes BYPASS (code 11).
- R2: Driving `trst_n` low puts the block into the reset state at once, without a clock edge. The active instruction becomes BYPASS, `bsr_mode` falls and `tdo_en` falls.
- R3: Capture-IR loads the fixed pattern 01 into the instruction shift stage. Shift-IR moves that stage one bit per rising edge toward `tdo`, least significant bit first, and takes `tdi` in at the top. A tester therefore reads 1 and then 0.
- R4: A shifted instruction becomes active only at the rising edge that leaves Update-IR. While it is being shifted or paused, the previous instruction and its `bsr_mode` value stay in effect.
- R5: Instruction codes 00 (EXTEST) and 01 (SAMPLE/PRELOAD) place the external boundary register, read through `bsr_so`, between `tdi` and `tdo`. Codes 10 and 11 both select the one-bit bypass register.
- R6: The bypass register loads 0 in Capture-DR and loads `tdi` on each Shift-DR edge. A scan through it therefore returns 0 followed by the input stream delayed by one bit.
- R7: `tdo` changes only on the falling edge of `tck`. `tdo_en` is high only in the half cycles that follow a falling edge taken in Shift-IR or Shift-DR.
- R8: `bsr_capture`, `bsr_shift` and `bsr_update` are asserted only in Capture-DR, Shift-DR and Update-DR respectively, and only while code 00 or 01 is active. With a bypass code active, the boundary register is left untouched.
- R9: `bsr_mode` is high exactly while EXTEST (code 00) is the active instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| bsr_so | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | High while `tdo` carries shifted data |
| bsr_capture | output | 1 | Boundary register parallel-capture enable |
| bsr_shift | output | 1 | Boundary register shift enable |
| bsr_update | output | 1 | Boundary register update enable |
| bsr_mode | output | 1 | Boundary register drives the pins (EXTEST active) |

## Verification
A state change and any capture take effect at a rising edge. The serial output reflects it after the next falling edge, so the first scanned bit is due half a cycle after the rising edge that enters a shift state. Each later bit is due one falling edge after the rising edge that shifted it. The bench drives `tms`/`tdi` and samples every output 1 ns after each falling edge. One dedicated check also samples just after a rising edge to confirm that `tdo` has not moved yet. The instruction-driven `bsr_mode` is due right after the rising edge that leaves Update-IR. The asynchronous reset is checked 1 ns after `trst_n` falls, with no clock edge in between.

// File: rtl/tap_pkg.sv
package tap_pkg;

   localparam int IR_W = 2;

   localparam logic [IR_W-1:0] OP_EXTEST = 2'b00;
   localparam logic [IR_W-1:0] OP_SAMPLE = 2'b01;
   localparam logic [IR_W-1:0] OP_BYPASS = 2'b11;

   typedef enum logic [3:0] {
      TS_RESET,  TS_IDLE,
      TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
      TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
   } tap_state_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e st
);

   tap_state_e st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         TS_RESET:  st_nx = tms ? TS_RESET  : TS_IDLE;
         TS_IDLE:   st_nx = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: st_nx = tms ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: st_nx = tms ? TS_EX1_DR : TS_SH_DR;
         TS_SH_DR:  st_nx = tms ? TS_EX1_DR : TS_SH_DR;
         TS_EX1_DR: st_nx = tms ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: st_nx = tms ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: st_nx = tms ? TS_UPD_DR : TS_SH_DR;
         TS_UPD_DR: st_nx = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: st_nx = tms ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: st_nx = tms ? TS_EX1_IR : TS_SH_IR;
         TS_SH_IR:  st_nx = tms ? TS_EX1_IR : TS_SH_IR;
         TS_EX1_IR: st_nx = tms ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: st_nx = tms ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: st_nx = tms ? TS_UPD_IR : TS_SH_IR;
         TS_UPD_IR: st_nx = tms ? TS_SEL_DR : TS_IDLE;
         default:   st_nx = TS_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) st <= TS_RESET;
      else         st <= st_nx;
   end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
#(
   parameter logic [IR_W-1:0] CAP_PAT  = 2'b01,
   parameter logic [IR_W-1:0] RESET_OP = OP_BYPASS
) (
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_e      st,
   input  logic            tdi,
   output logic            ir_so,
   output logic [IR_W-1:0] ir_q,
   output logic            bsr_sel,
   output logic            extest
);

   logic [IR_W-1:0] ir_sr;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sr <= CAP_PAT;
      end else if (st == TS_CAP_IR) begin
         ir_sr <= CAP_PAT;
      end else if (st == TS_SH_IR) begin
         ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                ir_q <= RESET_OP;
      else if (st == TS_RESET)    ir_q <= RESET_OP;
      else if (st == TS_UPD_IR)   ir_q <= ir_sr;
   end

   assign ir_so   = ir_sr[0];
   assign extest  = (ir_q == OP_EXTEST);
   assign bsr_sel = (ir_q == OP_EXTEST) || (ir_q == OP_SAMPLE);

endmodule

// File: rtl/tap_dr.sv
module tap_dr
   import tap_pkg::*;
#(
   parameter bit TDO_ON_FALL = 1'b1
) (
   input  logic       tck,
   input  logic       trst_n,
   input  tap_state_e st,
   input  logic       tdi,
   input  logic       bsr_sel,
   input  logic       ir_so,
   input  logic       bsr_so,
   output logic       byp_q,
   output logic       tdo,
   output logic       tdo_en
);

   logic in_shift;
   logic tdo_nx;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                          byp_q <= 1'b0;
      else if (!bsr_sel && st == TS_CAP_DR) byp_q <= 1'b0;
      else if (!bsr_sel && st == TS_SH_DR)  byp_q <= tdi;
   end

   assign in_shift = (st == TS_SH_DR) || (st == TS_SH_IR);

   always_comb begin
      if (st == TS_SH_IR)  tdo_nx = ir_so;
      else if (bsr_sel)    tdo_nx = bsr_so;
      else                 tdo_nx = byp_q;
   end

   generate
      if (TDO_ON_FALL) begin : g_fall
         logic tdo_r, en_r;
         always_ff @(negedge tck or negedge trst_n) begin
            if (!trst_n) begin
               tdo_r <= 1'b0;
               en_r  <= 1'b0;
            end else begin
               en_r <= in_shift;
               if (in_shift) tdo_r <= tdo_nx;
            end
         end
         assign tdo    = tdo_r;
         assign tdo_en = en_r;
      end else begin : g_comb
         assign tdo    = tdo_nx;
         assign tdo_en = in_shift;
      end
   endgenerate

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
   import tap_pkg::*;
#(
   parameter logic [IR_W-1:0] CAP_PAT     = 2'b01,
   parameter bit              TDO_ON_FALL = 1'b1
) (
   input  logic tck,
   input  logic trst_n,
   input  logic tms,
   input  logic tdi,
   input  logic bsr_so,
   output logic tdo,
   output logic tdo_en,
   output logic bsr_capture,
   output logic bsr_shift,
   output logic bsr_update,
   output logic bsr_mode
);

   generate
      if (CAP_PAT[1:0] != 2'b01) begin : g_bad_cap
         $error("tap_ctrl: capture pattern must end in binary 01");
      end
   endgenerate

   tap_state_e      st;
   logic [IR_W-1:0] ir_q;
   logic            ir_so;
   logic            bsr_sel;
   logic            extest;
   logic            byp_q;

   tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .st     (st)
   );

   tap_ir #(.CAP_PAT(CAP_PAT), .RESET_OP(OP_BYPASS)) u_ir (
      .tck     (tck),
      .trst_n  (trst_n),
      .st      (st),
      .tdi     (tdi),
      .ir_so   (ir_so),
      .ir_q    (ir_q),
      .bsr_sel (bsr_sel),
      .extest  (extest)
   );

   tap_dr #(.TDO_ON_FALL(TDO_ON_FALL)) u_dr (
      .tck     (tck),
      .trst_n  (trst_n),
      .st      (st),
      .tdi     (tdi),
      .bsr_sel (bsr_sel),
      .ir_so   (ir_so),
      .bsr_so  (bsr_so),
      .byp_q   (byp_q),
      .tdo     (tdo),
      .tdo_en  (tdo_en)
   );

   assign bsr_capture = bsr_sel && (st == TS_CAP_DR);
   assign bsr_shift   = bsr_sel && (st == TS_SH_DR);
   assign bsr_update  = bsr_sel && (st == TS_UPD_DR);
   assign bsr_mode    = extest;

endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
   import tap_pkg::*;
(
   input logic            tck,
   input logic            trst_n,
   input tap_state_e      st,
   input logic [IR_W-1:0] ir_q,
   input logic            byp_q,
   input logic            bsr_capture,
   input logic            bsr_shift,
   input logic            bsr_update,
   input logic            bsr_mode,
   input logic            tdo_en
);

   // R1
   reset_op_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == TS_RESET) |=> (ir_q == OP_BYPASS));

   // R4
   ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st != TS_UPD_IR && st != TS_RESET) |=> $stable(ir_q));

   // R5
   bsr_path_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (bsr_capture || bsr_shift || bsr_update) |-> (ir_q[1] == 1'b0));

   // R6
   byp_cap_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == TS_CAP_DR && ir_q[1]) |=> (byp_q == 1'b0));

   // R7
   tdo_en_chk: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en |-> (st == TS_SH_DR || st == TS_SH_IR));

   // R8
   strobe_excl_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0({bsr_capture, bsr_shift, bsr_update}));

   // R9
   mode_chk: assert property (@(posedge tck) disable iff (!trst_n)
      bsr_mode |-> (ir_q == OP_EXTEST));

endmodule

bind tap_ctrl tap_ctrl_chk u_chk (
   .tck         (tck),
   .trst_n      (trst_n),
   .st          (st),
   .ir_q        (ir_q),
   .byp_q       (byp_q),
   .bsr_capture (bsr_capture),
   .bsr_shift   (bsr_shift),
   .bsr_update  (bsr_update),
   .bsr_mode    (bsr_mode),
   .tdo_en      (tdo_en)
);

// File: tb/sim_tap_ctrl.sv
`timescale 1ns/1ps
module sim_tap_ctrl;

   localparam int BSR_N = 4;

   logic tck = 1'b0;
   logic trst_n = 1'b0;
   logic tms = 1'b1;
   logic tdi = 1'b0;
   logic bsr_so;
   logic tdo, tdo_en, bsr_capture, bsr_shift, bsr_update, bsr_mode;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 tck = ~tck;

   tap_ctrl u0 (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
      .tdo(tdo), .tdo_en(tdo_en), .bsr_capture(bsr_capture),
      .bsr_shift(bsr_shift), .bsr_update(bsr_update), .bsr_mode(bsr_mode)
   );

   // external boundary register model
   logic [BSR_N-1:0] pins = '0;
   logic [BSR_N-1:0] bsr_sr = '0;
   logic [BSR_N-1:0] bsr_out = '0;
   always @(posedge tck) begin
      if (bsr_capture)    bsr_sr <= pins;
      else if (bsr_shift) bsr_sr <= {tdi, bsr_sr[BSR_N-1:1]};
      if (bsr_update)     bsr_out <= bsr_sr;
   end
   assign bsr_so = bsr_sr[0];

   task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic m, input logic d);
      tms = m;
      tdi = d;
      @(posedge tck);
      @(negedge tck);
      #1;
   endtask

   // from IDLE, loads an instruction and returns to IDLE; returns captured bits
   task automatic load_ir(input logic [1:0] code, output logic [1:0] cap);
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 2; i++) begin
         cap[i] = tdo;
         step(i == 1, code[i]);
      end
      step(1, 0); step(0, 0);
   endtask

   // from IDLE, scans n bits through the selected data register and returns to IDLE
   task automatic scan_dr(input int n, input logic [7:0] din, output logic [7:0] dout);
      dout = '0;
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < n; i++) begin
         dout[i] = tdo;
         step(i == n - 1, din[i]);
      end
      step(1, 0); step(0, 0);
   endtask

   task automatic path_of(input int k, output int len, output logic [7:0] bits);
      case (k)
         0:  begin len = 3; bits = 8'b111;    end
         1:  begin len = 0; bits = 8'b0;      end
         2:  begin len = 1; bits = 8'b1;      end
         3:  begin len = 2; bits = 8'b01;     end
         4:  begin len = 3; bits = 8'b001;    end
         5:  begin len = 3; bits = 8'b101;    end
         6:  begin len = 4; bits = 8'b0101;   end
         7:  begin len = 5; bits = 8'b10101;  end
         8:  begin len = 4; bits = 8'b1101;   end
         9:  begin len = 2; bits = 8'b11;     end
         10: begin len = 3; bits = 8'b011;    end
         11: begin len = 4; bits = 8'b0011;   end
         12: begin len = 4; bits = 8'b1011;   end
         13: begin len = 5; bits = 8'b01011;  end
         14: begin len = 6; bits = 8'b101011; end
         default: begin len = 5; bits = 8'b11011; end
      endcase
   endtask

   initial begin
      repeat (200000) @(posedge tck);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [1:0] cap;
      logic [7:0] dout, din, expv;
      int         len;
      logic [7:0] bits;

      repeat (3) @(negedge tck);
      #1;
      // R2: reset state
      chk(bsr_mode == 0 && tdo_en == 0, "R2 reset outputs", {6'd0, bsr_mode, tdo_en}, 8'h00);
      chk({bsr_capture, bsr_shift, bsr_update} == 3'b000, "R8 idle strobes",
          {5'd0, bsr_capture, bsr_shift, bsr_update}, 8'h00);
      trst_n = 1'b1;
      step(0, 0); // IDLE

      // sweep of all instruction codes
      for (int c = 3; c >= 0; c--) begin
         logic [BSR_N-1:0] prev_out;
         load_ir(c[1:0], cap);
         chk(cap == 2'b01, "R3 capture pattern", {6'd0, cap}, 8'h01);
         chk(bsr_mode == (c == 0), "R9 mode flag", {7'd0, bsr_mode}, {7'd0, c == 0});
         pins = 4'h5 ^ (c[3:0] * 4'd3);
         din  = 8'hA7 ^ (c[7:0] * 8'h1D);
         prev_out = bsr_out;
         scan_dr(8, din, dout);
         if (c >= 2) begin
            expv = {din[6:0], 1'b0};
            chk(dout == expv, "R6 bypass scan", dout, expv);
            chk(bsr_out == prev_out, "R8 boundary untouched", {4'd0, bsr_out}, {4'd0, prev_out});
         end else begin
            expv = {din[3:0], pins};
            chk(dout == expv, "R5 boundary scan", dout, expv);
            chk(bsr_out == din[7:4], "R8 boundary update", {4'd0, bsr_out}, {4'd0, din[7:4]});
         end
      end

      // R4: EXTEST active (last of sweep); shift BYPASS and pause before update
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      step(0, 1); step(1, 1); // Exit1-IR
      step(0, 0);             // Pause-IR
      chk(bsr_mode == 1'b1, "R4 instruction held while paused", {7'd0, bsr_mode}, 8'h01);
      chk(tdo_en == 1'b0, "R7 no output in pause", {7'd0, tdo_en}, 8'h00);
      step(1, 0); step(1, 0); // Exit2-IR, Update-IR
      chk(bsr_mode == 1'b1, "R4 held in update state", {7'd0, bsr_mode}, 8'h01);
      step(0, 0);
      chk(bsr_mode == 1'b0, "R4 applied after update", {7'd0, bsr_mode}, 8'h00);

      // R7: output moves on falling edge only (bypass active)
      step(1, 0); step(0, 0); step(0, 0);
      chk(tdo == 1'b0 && tdo_en == 1'b1, "R7 first bypass bit", {6'd0, tdo, tdo_en}, 8'h01);
      tms = 0; tdi = 1;
      @(posedge tck); #1;
      chk(tdo == 1'b0, "R7 tdo steady after rise", {7'd0, tdo}, 8'h00);
      @(negedge tck); #1;
      chk(tdo == 1'b1, "R7 tdo updated after fall", {7'd0, tdo}, 8'h01);
      step(1, 0);
      chk(tdo_en == 1'b0, "R7 enable low in exit", {7'd0, tdo_en}, 8'h00);
      step(0, 0); step(1, 0); step(1, 0); step(0, 0);

      // R1: five TMS-high clocks reach reset from each of the sixteen states
      for (int k = 0; k < 16; k++) begin
         load_ir(2'b00, cap);
         path_of(k, len, bits);
         for (int i = 0; i < len; i++) step(bits[i], 0);
         for (int i = 0; i < 5; i++) step(1, 0);
         step(0, 0);
         chk(bsr_mode == 1'b0, $sformatf("R1 mode after reset from state %0d", k),
             {7'd0, bsr_mode}, 8'h00);
         scan_dr(3, 8'h07, dout);
         chk(dout == 8'h06, $sformatf("R1 bypass after reset from state %0d", k), dout, 8'h06);
      end

      // R2: asynchronous reset while idle and while shifting
      load_ir(2'b00, cap);
      chk(bsr_mode == 1'b1, "R9 extest loaded", {7'd0, bsr_mode}, 8'h01);
      trst_n = 1'b0; #1;
      chk(bsr_mode == 1'b0, "R2 async mode drop", {7'd0, bsr_mode}, 8'h00);
      @(negedge tck); #1; trst_n = 1'b1;
      step(0, 0);
      step(1, 0); step(0, 0); step(0, 0);
      chk(tdo_en == 1'b1, "R7 enable in shift", {7'd0, tdo_en}, 8'h01);
      trst_n = 1'b0; #1;
      chk(tdo_en == 1'b0, "R2 async enable drop", {7'd0, tdo_en}, 8'h00);
      @(negedge tck); #1; trst_n = 1'b1;
      step(0, 0);
      scan_dr(2, 8'h01, dout);
      chk(dout == 8'h02, "R2 bypass after async reset", dout, 8'h02);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule